// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block connects a synchronous 32-bit host request port to an external bus for asynchronous static memories. The host side issues one request at a time. A request carries an address, write data, four byte strobes and a read/write flag, with a valid/ready handshake. Each request ends with a one-cycle response that carries an error flag and the read data.

The external side has a 16-bit data path split into output, input and output-enable pins, 26 address lines and four active-low chip selects. It also has active-low output enable, write enable and upper/lower byte enables. Host addresses whose top nibble is 0x6 fall in a 256 MB window, and address bits 27:26 pick one of four 64 MB regions. Each region has its own control word and timing word, which are written and read through a small register port.

A sequencer runs every external cycle through named states:

- PH_IDLE waits for a request.
- PH_SETUP holds the address for setup+1 clocks.
- PH_DATA drives the strobes for data+1 clocks.
- PH_TURN keeps every select high for the turnaround count.
- PH_RESP presents the response for one clock.

The transitions are:

- PH_IDLE goes to PH_SETUP on an accepted legal request, or to PH_RESP on an illegal one.
- PH_SETUP goes to PH_DATA when its count runs out.
- PH_DATA goes to PH_TURN when its count runs out and the turnaround is non-zero. Otherwise it goes to PH_SETUP for the next beat, or to PH_RESP after the last beat.
- PH_TURN goes to PH_SETUP for the next beat, or to PH_RESP after the last beat.
- PH_RESP returns to PH_IDLE.

A region in 16-bit mode uses two beats per host word. A region in 8-bit mode uses four beats.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, every control word reads 0. Every timing word reads 0x000F_FF0F, which is all fields at maximum. mem_dq_oe is low, all four mem_ce_n bits, mem_oe_n and mem_we_n are high, req_ready is high and rsp_valid is low.
- R2: Register slot 2n holds the control word of region n and slot 2n+1 holds its timing word. Control word: bit 0 enables the region, bit 1 permits writes, bit 2 selects 16-bit width (when clear the region is 8-bit). Timing word: setup count in bits 3:0, data count in bits 15:8, turnaround count in bits 19:16. A written value reads back unchanged on cfg_rdata.
- R3: A request whose address bits 31:28 equal 0x6 targets region n = address bits 27:26. During that region's external cycles only mem_ce_n[n] is low.
- R4: A request outside the window, or to a region whose enable bit is clear, produces rsp_valid with rsp_err=1 in the cycle after acceptance. No chip select goes low.
- R5: A write to an enabled region whose write-permit bit is clear ends with rsp_err=1 and no chip select going low. Reads of that region complete normally.
- R6: Each external cycle keeps its chip select low for (setup+1)+(data+1) clocks. mem_we_n is low for exactly data clocks, starting with the first data-phase clock. On reads, mem_oe_n is low for data+1 clocks. mem_oe_n is never low while mem_dq_oe is high.
- R7: After every external cycle, all chip selects stay high for exactly the turnaround count of clocks before the next cycle of the same request. With a turnaround of 0, the select stays low across beats.
- R8: In 16-bit mode, a host word becomes two external cycles. The low half-word goes out first, at mem_addr = {0, addr[25:2], 0}, and the high half-word follows at the next half-word address.
- R9: In 8-bit mode, a host word becomes four external cycles in byte order on mem_dq_o[7:0] (upper byte 0), at mem_addr = {addr[25:2], beat}, with mem_ub_n held high.
- R10: During an external cycle, each byte enable is the inverse of the host strobe for the byte lane being carried. mem_lb_n carries the lower lane and mem_ub_n the upper lane.
- R11: Read data is taken from mem_dq_i on the last data-phase clock of each beat and assembled in beat order into rsp_rdata.
- R12: req_ready is high only in the idle state. Every accepted request yields exactly one rsp_valid pulse, and req_ready returns in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 32 | Host write data |
| req_strb | input | 4 | Host byte strobes |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request refused |
| rsp_rdata | output | 32 | Assembled read data |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register slot index |
| cfg_wdata | input | 32 | Register write value |
| cfg_rdata | output | 32 | Register slot contents |
| mem_addr | output | 26 | External address |
| mem_dq_o | output | 16 | External write data |
| mem_dq_i | input | 16 | External read data |
| mem_dq_oe | output | 1 | Data bus drive enable (low = tri-stated) |
| mem_ce_n | output | 4 | Chip selects, one per region |
| mem_oe_n | output | 1 | Output enable |
| mem_we_n | output | 1 | Write enable |
| mem_ub_n | output | 1 | Upper byte enable |
| mem_lb_n | output | 1 | Lower byte enable |

## Verification
The hardest situation to reach from the ports is the timing of the beats inside one host request. Each turnaround gap, write-enable pulse and merged chip-select run shows only as pin activity that never reaches the response. The stimulus reprograms each region with different setup, data and turnaround counts, including the all-maximum reset timing and a zero turnaround. A pin monitor measures every low run and every gap of the selects and strobes, and compares each one against the counts the bench last wrote. Refused requests are checked by confirming that the monitor's count of chip-select falls did not move.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    parameter int AS_W = 4;
    parameter int DS_W = 8;
    parameter int BT_W = 4;
    localparam int MAX_AD = (AS_W > DS_W) ? AS_W : DS_W;
    localparam int CNT_W  = (MAX_AD > BT_W) ? MAX_AD : BT_W;

    localparam int CTL_EN  = 0;
    localparam int CTL_WEN = 1;
    localparam int CTL_WID = 2;
    localparam int TIM_AS_LSB = 0;
    localparam int TIM_DS_LSB = 8;
    localparam int TIM_BT_LSB = 16;

    localparam logic [31:0] TIM_RESET =
        (32'((1 << BT_W) - 1) << TIM_BT_LSB) |
        (32'((1 << DS_W) - 1) << TIM_DS_LSB) |
        (32'((1 << AS_W) - 1) << TIM_AS_LSB);

    typedef struct packed {
        logic            en;
        logic            wen;
        logic            wide;
        logic [AS_W-1:0] addset;
        logic [DS_W-1:0] datast;
        logic [BT_W-1:0] busturn;
    } rgn_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_DATA,
        PH_TURN,
        PH_RESP
    } phase_t;

    function automatic rgn_cfg_t unpack_cfg(input logic [31:0] ctl, input logic [31:0] tim);
        rgn_cfg_t c;
        c.en      = ctl[CTL_EN];
        c.wen     = ctl[CTL_WEN];
        c.wide    = ctl[CTL_WID];
        c.addset  = tim[TIM_AS_LSB +: AS_W];
        c.datast  = tim[TIM_DS_LSB +: DS_W];
        c.busturn = tim[TIM_BT_LSB +: BT_W];
        return c;
    endfunction
endpackage

// File: rtl/sbc_regs.sv
module sbc_regs
    import sbc_pkg::*;
#(
    parameter int NRGN = 4,
    localparam int NSLOT = 2 * NRGN,
    localparam int IDX_W = $clog2(NSLOT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [IDX_W-1:0]            cfg_idx,
    input  logic [31:0]                 cfg_wdata,
    output logic [31:0]                 cfg_rdata,
    output logic [NSLOT-1:0][31:0]      slots
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [31:0] RV = (g % 2 == 0) ? 32'h0 : TIM_RESET;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots[g] <= RV;
            end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
                slots[g] <= cfg_wdata;
            end
        end
    end

    assign cfg_rdata = slots[cfg_idx];
endmodule

// File: rtl/sbc_decode.sv
module sbc_decode
    import sbc_pkg::*;
#(
    parameter int NRGN = 4,
    parameter logic [3:0] WIN_TAG = 4'h6,
    localparam int RSEL_W = $clog2(NRGN),
    localparam int NSLOT = 2 * NRGN
) (
    input  logic [31:0]             addr,
    input  logic [NSLOT-1:0][31:0]  slots,
    output logic                    hit,
    output logic [RSEL_W-1:0]       rsel,
    output rgn_cfg_t                cfg
);
    logic [31:0] ctl;
    logic [31:0] tim;

    assign hit  = (addr[31:28] == WIN_TAG);
    assign rsel = addr[27 -: RSEL_W];
    assign ctl  = slots[{rsel, 1'b0}];
    assign tim  = slots[{rsel, 1'b1}];
    assign cfg  = unpack_cfg(ctl, tim);

    logic unused_dec;
    assign unused_dec = ^{addr[27-RSEL_W:0], ctl, tim};
endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
    import sbc_pkg::*;
#(
    parameter int NRGN = 4,
    parameter int EA_W = 26,
    localparam int RSEL_W = $clog2(NRGN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                fail,
    input  logic                write,
    input  rgn_cfg_t            cfg,
    input  logic [RSEL_W-1:0]   rsel,
    input  logic [EA_W-3:0]     widx,
    input  logic [31:0]         wdata,
    input  logic [3:0]          strb,
    output logic                idle,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [31:0]         rsp_rdata,
    output logic [EA_W-1:0]     mem_addr,
    output logic [15:0]         mem_dq_o,
    input  logic [15:0]         mem_dq_i,
    output logic                mem_dq_oe,
    output logic [NRGN-1:0]     mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic                mem_ub_n,
    output logic                mem_lb_n
);
    phase_t             ph, ph_nxt;
    logic [CNT_W-1:0]   cnt, cnt_nxt;
    logic [1:0]         beat;
    logic               adv;
    logic               last_beat;
    rgn_cfg_t           lc;
    logic [RSEL_W-1:0]  lrsel;
    logic               lwr;
    logic [EA_W-3:0]    lidx;
    logic [31:0]        lwd;
    logic [3:0]         lst;
    logic               err;
    logic [31:0]        rdata;
    logic               active;

    assign last_beat = lc.wide ? beat[0] : (beat == 2'd3);

    // next phase and count
    always_comb begin
        ph_nxt  = ph;
        cnt_nxt = cnt;
        adv     = 1'b0;
        unique case (ph)
            PH_IDLE: begin
                if (start) begin
                    ph_nxt  = PH_SETUP;
                    cnt_nxt = CNT_W'(cfg.addset);
                end else if (fail) begin
                    ph_nxt = PH_RESP;
                end
            end
            PH_SETUP: begin
                if (cnt == '0) begin
                    ph_nxt  = PH_DATA;
                    cnt_nxt = CNT_W'(lc.datast);
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
            PH_DATA: begin
                if (cnt == '0) begin
                    if (lc.busturn != '0) begin
                        ph_nxt  = PH_TURN;
                        cnt_nxt = CNT_W'(lc.busturn) - CNT_W'(1);
                    end else if (last_beat) begin
                        ph_nxt = PH_RESP;
                    end else begin
                        ph_nxt  = PH_SETUP;
                        cnt_nxt = CNT_W'(lc.addset);
                        adv     = 1'b1;
                    end
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
            PH_TURN: begin
                if (cnt == '0) begin
                    if (last_beat) begin
                        ph_nxt = PH_RESP;
                    end else begin
                        ph_nxt  = PH_SETUP;
                        cnt_nxt = CNT_W'(lc.addset);
                        adv     = 1'b1;
                    end
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
            PH_RESP: ph_nxt = PH_IDLE;
            default: ph_nxt = PH_IDLE;
        endcase
    end

    // state register and request snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            beat  <= '0;
            lc    <= '0;
            lrsel <= '0;
            lwr   <= 1'b0;
            lidx  <= '0;
            lwd   <= '0;
            lst   <= '0;
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            ph  <= ph_nxt;
            cnt <= cnt_nxt;
            if (ph == PH_IDLE && (start || fail)) begin
                lc    <= cfg;
                lrsel <= rsel;
                lwr   <= write;
                lidx  <= widx;
                lwd   <= wdata;
                lst   <= strb;
                err   <= fail;
                rdata <= '0;
                beat  <= '0;
            end
            if (adv) begin
                beat <= beat + 2'd1;
            end
            if (ph == PH_DATA && cnt == '0 && !lwr) begin
                if (lc.wide) begin
                    rdata[{beat[0], 4'b0} +: 16] <= mem_dq_i;
                end else begin
                    rdata[{beat, 3'b0} +: 8] <= mem_dq_i[7:0];
                end
            end
        end
    end

    // outputs
    always_comb begin
        active    = (ph == PH_SETUP) || (ph == PH_DATA);
        mem_ce_n  = '1;
        if (active) begin
            mem_ce_n[lrsel] = 1'b0;
        end
        mem_oe_n  = !(ph == PH_DATA && !lwr);
        mem_we_n  = !(ph == PH_DATA && lwr && cnt != '0);
        mem_dq_oe = active && lwr;
        if (lc.wide) begin
            mem_addr = {1'b0, lidx, beat[0]};
            mem_dq_o = lwd[{beat[0], 4'b0} +: 16];
            mem_lb_n = ~lst[{beat[0], 1'b0}];
            mem_ub_n = ~lst[{beat[0], 1'b1}];
        end else begin
            mem_addr = {lidx, beat};
            mem_dq_o = {8'h00, lwd[{beat, 3'b0} +: 8]};
            mem_lb_n = ~lst[beat];
            mem_ub_n = 1'b1;
        end
        if (!active) begin
            mem_lb_n = 1'b1;
            mem_ub_n = 1'b1;
        end
        idle      = (ph == PH_IDLE);
        rsp_valid = (ph == PH_RESP);
        rsp_err   = err;
        rsp_rdata = rdata;
    end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sbc_pkg::*;
#(
    parameter int NRGN = 4,
    parameter logic [3:0] WIN_TAG = 4'h6,
    localparam int RSEL_W = $clog2(NRGN),
    localparam int IDX_W = $clog2(2 * NRGN),
    localparam int EA_W = 28 - RSEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [31:0]         req_addr,
    input  logic [31:0]         req_wdata,
    input  logic [3:0]          req_strb,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [31:0]         rsp_rdata,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    output logic [EA_W-1:0]     mem_addr,
    output logic [15:0]         mem_dq_o,
    input  logic [15:0]         mem_dq_i,
    output logic                mem_dq_oe,
    output logic [NRGN-1:0]     mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic                mem_ub_n,
    output logic                mem_lb_n
);
    logic [2*NRGN-1:0][31:0] slots;
    logic                    hit;
    logic [RSEL_W-1:0]       rsel;
    rgn_cfg_t                cfg;
    logic                    idle;
    logic                    accept;
    logic                    legal;

    sbc_regs #(.NRGN(NRGN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .slots     (slots)
    );

    sbc_decode #(.NRGN(NRGN), .WIN_TAG(WIN_TAG)) u_decode (
        .addr  (req_addr),
        .slots (slots),
        .hit   (hit),
        .rsel  (rsel),
        .cfg   (cfg)
    );

    assign req_ready = idle;
    assign accept    = req_valid && idle;
    assign legal     = hit && cfg.en && (!req_write || cfg.wen);

    sbc_seq #(.NRGN(NRGN), .EA_W(EA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept && legal),
        .fail      (accept && !legal),
        .write     (req_write),
        .cfg       (cfg),
        .rsel      (rsel),
        .widx      (req_addr[EA_W-1:2]),
        .wdata     (req_wdata),
        .strb      (req_strb),
        .idle      (idle),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_i  (mem_dq_i),
        .mem_dq_oe (mem_dq_oe),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_ub_n  (mem_ub_n),
        .mem_lb_n  (mem_lb_n)
    );

    logic unused_top;
    assign unused_top = ^req_addr[1:0];
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int NRGN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_err,
    input logic [NRGN-1:0] mem_ce_n,
    input logic            mem_oe_n,
    input logic            mem_we_n,
    input logic            mem_dq_oe
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_tristate_R1: assert (!mem_dq_oe && (&mem_ce_n));
        end
    end

    assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ce_n));

    assert_error_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ((&mem_ce_n) && $past(&mem_ce_n)));

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n));

    assert_we_inside_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_ce_n) != {NRGN{1'b1}}));

    assert_ready_after_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));
endmodule

bind sram_bus_ctrl sbc_checker #(.NRGN(NRGN)) u_sbc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_bus_ctrl.sv
module test_sram_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_strb = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [25:0] mem_addr;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i;
    logic        mem_dq_oe;
    logic [3:0]  mem_ce_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic        mem_ub_n;
    logic        mem_lb_n;

    always #10 clk = ~clk;

    sram_bus_ctrl i_sram_bus_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n)
    );

    function automatic logic [15:0] mem_word(input logic [25:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0]};
    endfunction

    assign mem_dq_i = mem_oe_n ? 16'h0000 : mem_word(mem_addr);

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // scoreboard items
    typedef struct packed {
        logic [3:0]  ce;
        logic [25:0] a;
        logic [15:0] d;
        logic        ub;
        logic        lb;
    } wev_t;
    typedef struct packed {
        logic        err;
        logic [31:0] d;
        logic        chk_d;
    } rsp_t;
    wev_t exp_w[$];
    rsp_t exp_r[$];

    int rsp_seen = 0;
    int ce_falls = 0;
    int exp_ce_len = 0;
    int exp_we_len = 0;
    int exp_oe_len = 0;
    int last_gap = -1;

    // shadow of the programmed region settings
    bit b_en[4];
    bit b_wen[4];
    bit b_wide[4];
    int b_as[4];
    int b_ds[4];
    int b_bt[4];

    // pin monitor
    bit prev_ceh = 1'b1;
    bit prev_we = 1'b1;
    bit prev_oe = 1'b1;
    int ce_run = 0;
    int we_run = 0;
    int oe_run = 0;
    int gap = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!(&mem_ce_n)) begin
                if (prev_ceh) begin
                    ce_falls++;
                    last_gap = gap;
                end
                ce_run++;
            end else begin
                if (!prev_ceh) begin
                    check(ce_run == exp_ce_len, "R6", "select low length", ce_run, exp_ce_len);
                    ce_run = 0;
                    gap = 1;
                end else begin
                    gap++;
                end
            end
            if (!mem_we_n) begin
                we_run++;
            end else if (!prev_we) begin
                wev_t e;
                check(we_run == exp_we_len, "R6", "write pulse length", we_run, exp_we_len);
                we_run = 0;
                if (exp_w.size() == 0) begin
                    check(1'b0, "R8 R9", "unexpected external write", 32'(mem_addr), 0);
                end else begin
                    e = exp_w.pop_front();
                    check({mem_ce_n, mem_ub_n, mem_lb_n} == {e.ce, e.ub, e.lb}, "R3 R10",
                          "select/byte enables", 32'({mem_ce_n, mem_ub_n, mem_lb_n}),
                          32'({e.ce, e.ub, e.lb}));
                    check(mem_addr == e.a, "R8 R9", "write address", 32'(mem_addr), 32'(e.a));
                    check(mem_dq_o == e.d && mem_dq_oe, "R8 R9", "write data",
                          {15'h0, mem_dq_oe, mem_dq_o}, {16'h0001, e.d});
                end
            end
            if (!mem_oe_n) begin
                oe_run++;
            end else if (!prev_oe) begin
                check(oe_run == exp_oe_len, "R6", "output enable length", oe_run, exp_oe_len);
                oe_run = 0;
            end
            if (rsp_valid) begin
                rsp_t r;
                rsp_seen++;
                if (exp_r.size() == 0) begin
                    check(1'b0, "R12", "unexpected response", 32'(rsp_err), 0);
                end else begin
                    r = exp_r.pop_front();
                    check(rsp_err == r.err, "R12", "response error flag", 32'(rsp_err), 32'(r.err));
                    if (r.chk_d) begin
                        check(rsp_rdata == r.d, "R11", "read data", rsp_rdata, r.d);
                    end
                end
            end
            prev_ceh = &mem_ce_n;
            prev_we = mem_we_n;
            prev_oe = mem_oe_n;
        end
    end

    task automatic cfg_write(input int idx, input logic [31:0] v);
        int r;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_idx = 3'(idx);
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        r = idx / 2;
        if (idx % 2 == 0) begin
            b_en[r] = v[0];
            b_wen[r] = v[1];
            b_wide[r] = v[2];
        end else begin
            b_as[r] = int'(v[3:0]);
            b_ds[r] = int'(v[15:8]);
            b_bt[r] = int'(v[19:16]);
        end
    endtask

    task automatic cfg_check(input int idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_idx = 3'(idx);
        #1;
        check(cfg_rdata == exp, tag, "register readback", cfg_rdata, exp);
    endtask

    // driver: computes expectations from the requirements and issues one request
    task automatic xfer(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] s);
        int r;
        int nb;
        bit err;
        int base_falls;
        int target;
        logic [31:0] er;
        rsp_t rr;
        r = int'(a[27:26]);
        err = (a[31:28] != 4'h6) || !b_en[r] || (wr && !b_wen[r]);
        nb = b_wide[r] ? 2 : 4;
        base_falls = ce_falls;
        target = rsp_seen + 1;
        er = '0;
        if (!err) begin
            exp_ce_len = (b_bt[r] == 0) ? nb * (b_as[r] + b_ds[r] + 2) : (b_as[r] + b_ds[r] + 2);
            exp_we_len = b_ds[r];
            exp_oe_len = b_ds[r] + 1;
            for (int b = 0; b < nb; b++) begin
                wev_t e;
                logic [25:0] ea;
                ea = b_wide[r] ? {1'b0, a[25:2], 1'(b)} : {a[25:2], 2'(b)};
                e.ce = ~(4'b0001 << r);
                e.a = ea;
                if (b_wide[r]) begin
                    e.d = d[16*b +: 16];
                    e.lb = ~s[2*b];
                    e.ub = ~s[2*b+1];
                    er[16*b +: 16] = mem_word(ea);
                end else begin
                    e.d = {8'h00, d[8*b +: 8]};
                    e.lb = ~s[b];
                    e.ub = 1'b1;
                    er[8*b +: 8] = mem_word(ea)[7:0];
                end
                if (wr) exp_w.push_back(e);
            end
        end
        rr.err = err;
        rr.d = er;
        rr.chk_d = !wr && !err;
        exp_r.push_back(rr);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr = a;
        req_wdata = d;
        req_strb = s;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R12", "ready low after accept", 32'(req_ready), 0);
        while (rsp_seen < target) @(negedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R12", "ready back after response", 32'(req_ready), 1);
        if (err) begin
            check(ce_falls == base_falls, wr && a[31:28] == 4'h6 && b_en[r] ? "R5" : "R4",
                  "no select on refused request", ce_falls - base_falls, 0);
        end else if (b_bt[r] != 0) begin
            check(last_gap == b_bt[r], "R7", "turnaround gap", last_gap, b_bt[r]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R12 watchdog: actual=hung expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            b_en[i] = 1'b0; b_wen[i] = 1'b0; b_wide[i] = 1'b0;
            b_as[i] = 15; b_ds[i] = 255; b_bt[i] = 15;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the pins and in the registers
        check(req_ready && !rsp_valid, "R1", "handshake after reset",
              32'({req_ready, rsp_valid}), 32'h2);
        check(!mem_dq_oe && mem_ce_n == 4'hF && mem_oe_n && mem_we_n, "R1", "bus idle after reset",
              32'({mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n}), 32'h3F);
        for (int i = 0; i < 8; i++) begin
            cfg_check(i, (i % 2 == 0) ? 32'h0 : 32'h000F_FF0F, "R1");
        end
        // R4: disabled region and out-of-window requests
        xfer(1'b1, 32'h6000_0010, 32'h1234_5678, 4'hF);
        xfer(1'b0, 32'h7000_0000, 32'h0, 4'hF);
        xfer(1'b0, 32'h5FFF_FFFC, 32'h0, 4'hF);
        // R2 R8: region 0, 16-bit, reset (maximum) timing
        cfg_write(0, 32'h0000_0007);
        cfg_check(0, 32'h0000_0007, "R2");
        xfer(1'b1, 32'h6000_0104, 32'hA1B2_C3D4, 4'hF);
        // R3 R10: region 1, short timing, partial strobes
        cfg_write(3, 32'h0001_0201);
        cfg_write(2, 32'h0000_0007);
        cfg_check(3, 32'h0001_0201, "R2");
        xfer(1'b1, 32'h6400_0020, 32'h1122_3344, 4'b0110);
        // R11: read back through region 1
        xfer(1'b0, 32'h6400_0020, 32'h0, 4'hF);
        // R5: region 2 enabled but write-protected
        cfg_write(5, 32'h0002_0300);
        cfg_write(4, 32'h0000_0005);
        xfer(1'b1, 32'h6800_0000, 32'hDEAD_BEEF, 4'hF);
        xfer(1'b0, 32'h6800_0008, 32'h0, 4'hF);
        // R9: region 3, 8-bit width
        cfg_write(7, 32'h0001_0101);
        cfg_write(6, 32'h0000_0003);
        xfer(1'b1, 32'h6C00_0044, 32'hCAFE_F00D, 4'b1011);
        xfer(1'b0, 32'h6C00_0044, 32'h0, 4'hF);
        // R7: zero turnaround keeps the select low across beats
        cfg_write(3, 32'h0000_0201);
        xfer(1'b1, 32'h6400_0030, 32'h5566_7788, 4'hF);
        xfer(1'b0, 32'h6400_0030, 32'h0, 4'hF);
        // R4: region 1 disabled again
        cfg_write(2, 32'h0);
        xfer(1'b0, 32'h6400_0030, 32'h0, 4'hF);
        repeat (4) @(negedge clk);
        check(exp_w.size() == 0 && exp_r.size() == 0, "R12", "scoreboard drained",
              32'(exp_w.size() + exp_r.size()), 0);
        finish_run();
    end
endmodule